// File: doc/BRIEF.md
# Movie Ticket Vending Controller

This block is the control core of a ticket dispenser. It is driven by five button pulses (up, down, left, right and select), each one clock wide and already debounced. A purchase runs through three stages in a fixed order. First the user picks one of four movies. Next the user sets how many tickets to buy. Then the user feeds in bills until the amount owed is covered. The same four direction buttons act as movie choices in the first stage, as quantity adjustment in the second, and as bill denominations in the third.

Once the total paid reaches the amount due, the controller computes the change. It then raises a blink enable for the display for a fixed number of clock cycles, which is five seconds at the target clock. When the blink period ends, every register returns to its reset value and the controller waits for the next customer.

All money values are counted in half-dollar units, so that amounts such as 13.50 are exact. Each movie has its own price parameter. The seven-segment driver, button debouncing and the bill acceptor hardware sit outside this block.

Top module: `ticket_vend_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, the outputs are: `movie_idx` = DEFAULT_MOVIE (0), `qty` = 1, `paid` = 0, `change` = 0, `blink_en` = 0. The controller is in the movie stage.
- R2: In the movie stage, up selects movie 0, right selects movie 1, left selects movie 2 and down selects movie 3. Select moves the controller to the quantity stage and keeps the chosen movie.
- R3: In the quantity stage, up adds one to `qty` and down subtracts one. A press that would take `qty` above MAX_QTY (9) or below 1 is ignored. Left and right are ignored. Select moves the controller to the bill stage.
- R4: In the bill stage, each direction press adds a bill to `paid`, in half-dollar units: up adds 2 ($1), down adds 10 ($5), left adds 20 ($10) and right adds 40 ($20). Select is ignored, and `paid` never decreases except when the registers are cleared.
- R5: The amount due is `qty` × the price of the selected movie. The default prices are 20, 24, 18 and 27 half-dollars for movies 0 to 3.
- R6: The first bill that brings `paid` to at least the amount due ends the purchase. In the next cycle `change` equals `paid` minus the amount due. At every other time `change` is 0, and buttons have no effect while the controller is in the done state.
- R7: `blink_en` rises in the cycle after the completing bill and stays high for exactly BLINK_CYCLES cycles. On the edge that ends the blink period, `movie_idx`, `qty`, `paid` and `change` return to their R1 values and the controller is back in the movie stage.
- R8: At most one button is acted on per clock. When several pulses coincide, the priority is select, then up, then down, then left, then right. Every effect appears on the output registers at the clock edge where the pulse is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_up | input | 1 | Up button pulse |
| btn_down | input | 1 | Down button pulse |
| btn_left | input | 1 | Left button pulse |
| btn_right | input | 1 | Right button pulse |
| btn_sel | input | 1 | Select button pulse |
| movie_idx | output | 2 | Selected movie |
| qty | output | QTY_W (4) | Ticket quantity |
| paid | output | AMT_W (10) | Running amount paid, half-dollars |
| change | output | AMT_W (10) | Change owed, half-dollars |
| blink_en | output | 1 | Display blink enable |

## Verification
The bench pushes the quantity past both of its limits. A design without clamping would wrap to 0 or pass 9. It also presses several buttons in the same cycle, including select together with a direction button in each stage. A wrong priority would either move the stage or change a value when it should not.

Payments are checked for exact coverage, which must give zero change, and for overshoot. A comparison that is off by one would end one bill too early or too late, and the change would be wrong. Buttons are pressed while the display blinks, and the blink length is counted cycle by cycle. A design that miscounts or forgets to clear would leave stale values behind, or would give the next purchase a blink period that is too short or too long.

// File: rtl/ticket_vend_pkg.sv
package ticket_vend_pkg;

    typedef enum logic [1:0] {
        ST_MOVIE = 2'd0,
        ST_QTY   = 2'd1,
        ST_PAY   = 2'd2,
        ST_DONE  = 2'd3
    } stage_e;

    typedef enum logic [2:0] {
        KEY_NONE  = 3'd0,
        KEY_SEL   = 3'd1,
        KEY_UP    = 3'd2,
        KEY_DOWN  = 3'd3,
        KEY_LEFT  = 3'd4,
        KEY_RIGHT = 3'd5
    } key_e;

    typedef struct packed {
        logic sel;
        logic up;
        logic down;
        logic left;
        logic right;
    } key_raw_t;

    localparam int NUM_MOVIES = 4;
    localparam int MOVIE_W    = 2;

    // Bill values in half-dollar units
    localparam int BILL_ONE    = 2;
    localparam int BILL_FIVE   = 10;
    localparam int BILL_TEN    = 20;
    localparam int BILL_TWENTY = 40;

    // Fixed priority: select, up, down, left, right
    function automatic key_e pick_key(input key_raw_t r);
        if (r.sel)        return KEY_SEL;
        else if (r.up)    return KEY_UP;
        else if (r.down)  return KEY_DOWN;
        else if (r.left)  return KEY_LEFT;
        else if (r.right) return KEY_RIGHT;
        else              return KEY_NONE;
    endfunction

    function automatic logic [MOVIE_W-1:0] movie_of_key(input key_e k);
        case (k)
            KEY_RIGHT: return 2'd1;
            KEY_LEFT:  return 2'd2;
            KEY_DOWN:  return 2'd3;
            default:   return 2'd0;
        endcase
    endfunction

    function automatic int bill_of_key(input key_e k);
        case (k)
            KEY_UP:    return BILL_ONE;
            KEY_DOWN:  return BILL_FIVE;
            KEY_LEFT:  return BILL_TEN;
            KEY_RIGHT: return BILL_TWENTY;
            default:   return 0;
        endcase
    endfunction

    function automatic logic is_direction(input key_e k);
        return (k == KEY_UP) || (k == KEY_DOWN) || (k == KEY_LEFT) || (k == KEY_RIGHT);
    endfunction

endpackage

// File: rtl/tv_key_arbiter.sv
module tv_key_arbiter
    import ticket_vend_pkg::*;
(
    input  key_raw_t raw,
    output key_e     key
);
    always_comb begin
        key = pick_key(raw);
    end
endmodule

// File: rtl/tv_qty_counter.sv
module tv_qty_counter #(
    parameter int QTY_W   = 4,
    parameter int MAX_QTY = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    input  logic             dec,
    output logic [QTY_W-1:0] qty
);
    localparam logic [QTY_W-1:0] QTY_MIN = QTY_W'(1);
    localparam logic [QTY_W-1:0] QTY_MAX = QTY_W'(MAX_QTY);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            qty <= QTY_MIN;
        end else if (inc && (qty < QTY_MAX)) begin
            qty <= qty + QTY_W'(1);
        end else if (dec && (qty > QTY_MIN)) begin
            qty <= qty - QTY_W'(1);
        end
    end
endmodule

// File: rtl/tv_pay_accum.sv
module tv_pay_accum #(
    parameter int AMT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             add_en,
    input  logic [AMT_W-1:0] bill,
    input  logic [AMT_W-1:0] due,
    output logic [AMT_W-1:0] paid,
    output logic [AMT_W-1:0] change,
    output logic             covered
);
    logic [AMT_W:0] sum;

    always_comb begin
        sum     = {1'b0, paid} + {1'b0, bill};
        covered = add_en && (sum >= {1'b0, due});
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            paid   <= '0;
            change <= '0;
        end else if (add_en) begin
            paid <= sum[AMT_W-1:0];
            if (covered) begin
                change <= sum[AMT_W-1:0] - due;
            end
        end
    end
endmodule

// File: rtl/tv_blink_timer.sv
module tv_blink_timer #(
    parameter int BLINK_CYCLES = 1000000000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic active,
    output logic expire
);
    localparam int CNT_W = $clog2(BLINK_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BLINK_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_comb begin
        expire = active && (cnt == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (expire) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (active) begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/ticket_vend_ctrl.sv
module ticket_vend_ctrl
    import ticket_vend_pkg::*;
#(
    parameter int DEFAULT_MOVIE = 0,
    parameter int PRICE_M0      = 20,
    parameter int PRICE_M1      = 24,
    parameter int PRICE_M2      = 18,
    parameter int PRICE_M3      = 27,
    parameter int QTY_W         = 4,
    parameter int MAX_QTY       = 9,
    parameter int AMT_W         = 10,
    parameter int BLINK_CYCLES  = 1000000000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             btn_up,
    input  logic             btn_down,
    input  logic             btn_left,
    input  logic             btn_right,
    input  logic             btn_sel,
    output logic [1:0]       movie_idx,
    output logic [QTY_W-1:0] qty,
    output logic [AMT_W-1:0] paid,
    output logic [AMT_W-1:0] change,
    output logic             blink_en
);
    localparam int PRICE_TAB [NUM_MOVIES] = '{PRICE_M0, PRICE_M1, PRICE_M2, PRICE_M3};
    localparam logic [MOVIE_W-1:0] MOVIE_RST = MOVIE_W'(DEFAULT_MOVIE);

    stage_e           stage_q, stage_d;
    key_raw_t         raw;
    key_e             key;
    logic [AMT_W-1:0] price_w;
    logic [AMT_W-1:0] due_w;
    logic [AMT_W-1:0] bill_w;
    logic             clr_all, qty_inc, qty_dec, add_en, movie_set;
    logic             covered, timer_exp;

    always_comb begin
        raw = '{sel: btn_sel, up: btn_up, down: btn_down, left: btn_left, right: btn_right};
    end

    tv_key_arbiter u_arb (
        .raw (raw),
        .key (key)
    );

    // Price lookup and amount due
    always_comb begin
        price_w = '0;
        for (int m = 0; m < NUM_MOVIES; m++) begin
            if (movie_idx == MOVIE_W'(m)) price_w = AMT_W'(PRICE_TAB[m]);
        end
        due_w  = AMT_W'(qty) * price_w;
        bill_w = AMT_W'(bill_of_key(key));
    end

    // Stage sequencing and per-stage key meaning
    always_comb begin
        stage_d   = stage_q;
        clr_all   = 1'b0;
        qty_inc   = 1'b0;
        qty_dec   = 1'b0;
        add_en    = 1'b0;
        movie_set = 1'b0;
        case (stage_q)
            ST_MOVIE: begin
                if (key == KEY_SEL) stage_d = ST_QTY;
                movie_set = is_direction(key);
            end
            ST_QTY: begin
                if (key == KEY_SEL) stage_d = ST_PAY;
                qty_inc = (key == KEY_UP);
                qty_dec = (key == KEY_DOWN);
            end
            ST_PAY: begin
                add_en = is_direction(key);
                if (covered) stage_d = ST_DONE;
            end
            default: begin
                if (timer_exp) begin
                    stage_d = ST_MOVIE;
                    clr_all = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= ST_MOVIE;
        end else begin
            stage_q <= stage_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            movie_idx <= MOVIE_RST;
        end else if (movie_set) begin
            movie_idx <= movie_of_key(key);
        end
    end

    tv_qty_counter #(
        .QTY_W   (QTY_W),
        .MAX_QTY (MAX_QTY)
    ) u_qty (
        .clk (clk),
        .rst (rst),
        .clr (clr_all),
        .inc (qty_inc),
        .dec (qty_dec),
        .qty (qty)
    );

    tv_pay_accum #(
        .AMT_W (AMT_W)
    ) u_pay (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr_all),
        .add_en  (add_en),
        .bill    (bill_w),
        .due     (due_w),
        .paid    (paid),
        .change  (change),
        .covered (covered)
    );

    tv_blink_timer #(
        .BLINK_CYCLES (BLINK_CYCLES)
    ) u_blink (
        .clk    (clk),
        .rst    (rst),
        .start  (covered),
        .active (blink_en),
        .expire (timer_exp)
    );

endmodule

// File: rtl/tv_ctrl_checker.sv
module tv_ctrl_checker #(
    parameter int QTY_W   = 4,
    parameter int MAX_QTY = 9,
    parameter int AMT_W   = 10
) (
    input logic             clk,
    input logic             rst,
    input logic [QTY_W-1:0] qty,
    input logic [AMT_W-1:0] paid,
    input logic [AMT_W-1:0] change,
    input logic [AMT_W-1:0] due,
    input logic             blink_en
);
    assert_qty_range_R3: assert property (@(posedge clk) disable iff (rst)
        (qty >= QTY_W'(1)) && (qty <= QTY_W'(MAX_QTY)));

    assert_qty_step_R3: assert property (@(posedge clk) disable iff (rst)
        !$fell(blink_en) |-> ((qty == $past(qty)) || (qty == $past(qty) + QTY_W'(1))
                              || (qty == $past(qty) - QTY_W'(1))));

    assert_paid_monotonic_R4: assert property (@(posedge clk) disable iff (rst)
        !$fell(blink_en) |-> (paid >= $past(paid)));

    assert_change_idle_zero_R6: assert property (@(posedge clk) disable iff (rst)
        !blink_en |-> (change == '0));

    assert_change_math_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(blink_en) |-> ({1'b0, paid} == {1'b0, due} + {1'b0, change}));

    assert_hold_in_blink_R7: assert property (@(posedge clk) disable iff (rst)
        (blink_en && $past(blink_en)) |-> ($stable(paid) && $stable(qty) && $stable(change)));

    assert_clear_after_blink_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(blink_en) |-> ((paid == '0) && (change == '0) && (qty == QTY_W'(1))));
endmodule

bind ticket_vend_ctrl tv_ctrl_checker #(
    .QTY_W   (QTY_W),
    .MAX_QTY (MAX_QTY),
    .AMT_W   (AMT_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .qty      (qty),
    .paid     (paid),
    .change   (change),
    .due      (due_w),
    .blink_en (blink_en)
);

// File: tb/ticket_vend_ctrl_tb_top.sv
`timescale 1ns/1ps
module ticket_vend_ctrl_tb_top;
    localparam int BLINK = 12;
    localparam int PRICES [4] = '{20, 24, 18, 27};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic b_up = 0, b_down = 0, b_left = 0, b_right = 0, b_sel = 0;
    logic [1:0] movie_idx;
    logic [3:0] qty;
    logic [9:0] paid, change;
    logic       blink_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    ticket_vend_ctrl #(.BLINK_CYCLES(BLINK)) dut_i (
        .clk(clk), .rst(rst),
        .btn_up(b_up), .btn_down(b_down), .btn_left(b_left), .btn_right(b_right), .btn_sel(b_sel),
        .movie_idx(movie_idx), .qty(qty), .paid(paid), .change(change), .blink_en(blink_en)
    );

    // Behavioural reference model
    int m_stage = 0, m_movie = 0, m_qty = 1, m_paid = 0, m_change = 0, m_blink = 0, m_cnt = 0;
    bit started = 0;

    task automatic model_clear();
        m_stage = 0; m_movie = 0; m_qty = 1; m_paid = 0; m_change = 0; m_blink = 0; m_cnt = 0;
    endtask

    always @(posedge clk) begin
        string k;
        int due;
        started = 1;
        k = b_sel ? "S" : b_up ? "U" : b_down ? "D" : b_left ? "L" : b_right ? "R" : "-";
        if (rst) model_clear();
        else begin
            case (m_stage)
                0: begin
                    if (k == "S") m_stage = 1;
                    else if (k == "U") m_movie = 0;
                    else if (k == "R") m_movie = 1;
                    else if (k == "L") m_movie = 2;
                    else if (k == "D") m_movie = 3;
                end
                1: begin
                    if (k == "S") m_stage = 2;
                    else if (k == "U" && m_qty < 9) m_qty++;
                    else if (k == "D" && m_qty > 1) m_qty--;
                end
                2: begin
                    if (k != "S" && k != "-") begin
                        m_paid += (k == "U") ? 2 : (k == "D") ? 10 : (k == "L") ? 20 : 40;
                        due = m_qty * PRICES[m_movie];
                        if (m_paid >= due) begin
                            m_change = m_paid - due; m_blink = 1; m_cnt = 0; m_stage = 3;
                        end
                    end
                end
                default: begin
                    if (m_cnt == BLINK - 1) model_clear();
                    else m_cnt++;
                end
            endcase
        end
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            check("R2", "movie_idx", int'(movie_idx), m_movie);
            check("R3", "qty", int'(qty), m_qty);
            check("R4", "paid", int'(paid), m_paid);
            check("R6", "change", int'(change), m_change);
            check("R7", "blink_en", int'(blink_en), m_blink);
        end
    end

    task automatic press(bit s, bit u, bit d, bit l, bit r);
        @(negedge clk);
        b_sel = s; b_up = u; b_down = d; b_left = l; b_right = r;
        @(negedge clk);
        b_sel = 0; b_up = 0; b_down = 0; b_left = 0; b_right = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle(4);
        check("R1", "reset movie", int'(movie_idx), 0);
        check("R1", "reset qty", int'(qty), 1);
        check("R1", "reset paid", int'(paid), 0);
        check("R1", "reset blink", int'(blink_en), 0);
        rst = 0;
        idle(2);
        // R2: movie keys
        press(0,0,0,0,1); check("R2", "right->1", int'(movie_idx), 1);
        press(0,0,1,0,0); check("R2", "down->3", int'(movie_idx), 3);
        press(0,1,1,1,1); check("R8", "up beats down/left/right", int'(movie_idx), 0);
        press(0,0,1,1,1); check("R8", "down beats left/right", int'(movie_idx), 3);
        press(0,0,0,1,1); check("R8", "left beats right", int'(movie_idx), 2);
        press(1,0,0,0,0);
        // R3: quantity stage, movie 2 price 18
        press(0,0,0,1,0); check("R3", "left ignored", int'(qty), 1);
        press(0,0,1,0,0); check("R3", "floor at 1", int'(qty), 1);
        for (int i = 0; i < 10; i++) press(0,1,0,0,0);
        check("R3", "ceiling at 9", int'(qty), 9);
        for (int i = 0; i < 6; i++) press(0,0,1,0,0);
        check("R3", "down to 3", int'(qty), 3);
        press(1,1,0,0,0); check("R8", "select beats up in qty", int'(qty), 3);
        // R4: bills, due = 3*18 = 54
        press(1,0,0,0,0); check("R4", "select ignored in pay", int'(paid), 0);
        press(0,1,0,0,0); check("R4", "$1", int'(paid), 2);
        press(0,0,1,0,0); check("R4", "$5", int'(paid), 12);
        press(0,0,0,1,0); check("R4", "$10", int'(paid), 32);
        press(1,0,0,0,1); check("R8", "select masks bill", int'(paid), 32);
        @(negedge clk); b_right = 1; @(negedge clk); b_right = 0;
        check("R6", "overshoot change", int'(change), 18);
        check("R7", "blink on", int'(blink_en), 1);
        press(0,1,0,0,0); check("R6", "keys ignored in done", int'(paid), 72);
        idle(BLINK);
        check("R7", "cleared paid", int'(paid), 0);
        check("R7", "cleared blink", int'(blink_en), 0);
        check("R7", "default movie", int'(movie_idx), 0);
        // Exact payment: movie 0, qty 1, due 20
        press(1,0,0,0,0); press(1,0,0,0,0);
        press(0,0,0,1,0);
        check("R6", "exact change zero", int'(change), 0);
        check("R5", "exact paid", int'(paid), 20);
        idle(BLINK + 2);
        // Movie 3 price 27, qty 2 due 54: 40+10+2 short, then +2 exact
        press(0,0,1,0,0); press(1,0,0,0,0);
        press(0,1,0,0,0); press(1,0,0,0,0);
        press(0,0,0,0,1); press(0,0,1,0,0); press(0,1,0,0,0);
        check("R6", "one short no blink", int'(blink_en), 0);
        press(0,1,0,0,0);
        check("R5", "due 54 met", int'(blink_en), 1);
        check("R6", "change zero at 54", int'(change), 0);
        idle(BLINK + 2);
        // Overshoot on movie 1 price 24, qty 1: 40 -> change 16
        press(0,0,0,0,1); press(1,0,0,0,0); press(1,0,0,0,0);
        press(0,0,0,0,1);
        check("R6", "change 16", int'(change), 16);
        idle(BLINK + 2);
        finish_run();
    end
endmodule